// File: doc/BRIEF.md
# Conditional Sum Adder

This block is a purely combinational binary adder with a parameterized width. It adds two unsigned operands and a carry-in, and produces a sum of the same width plus a carry-out. The width must be a power of two.

The structure is recursive. At each level the operands are split in the middle. The lower half is added with the real incoming carry. At the same time, two copies of the upper half are evaluated: one assumes an incoming carry of zero and the other assumes one. When the lower half's carry-out is known, it picks one of the two pre-computed upper results, and that pick covers the upper sum bits and the carry-out together.

The recursion ends at a single full adder. The critical path is therefore one full-adder delay plus one multiplexer stage per halving. The price is roughly three copies of every half-width adder at every level.

Top module: `cond_sum_adder`

## Requirements
- R1: For every pair of WIDTH-bit operands and either carry-in value, {cout, sum} equals the arithmetic value a + b + cin, taken as a WIDTH+1-bit number with cout as its bit WIDTH.
- R2: Bits [WIDTH/2-1:0] of sum depend only on the low halves of a and b and on cin. They equal the low half of (a_low + b_low + cin).
- R3: The two pre-computed upper results are consistent. For identical operands, the {cout, sum} obtained with cin=1 is exactly one greater than the one obtained with cin=0.
- R4: The lower half's carry-out selects the upper sum bits and the final carry-out as one unit. For example, 0x0000FFFF + 0x00000001 with cin=0 gives sum 0x00010000 and cout 0 at WIDTH=32.
- R5: With WIDTH=1 the block behaves exactly as a full adder, for all 8 input combinations.
- R6: WIDTH must be a power of two (1, 2, 4, …). Any other value stops elaboration with an error.
- R7: The block has no clock and no state. Its outputs follow an input change without waiting for any clock edge.
- R8: All-ones operands with cin=1 give sum all-ones and cout=1.
- R9: A carry travels the full width. An all-ones a with b=0 and cin=1 gives sum 0 and cout=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench targets the following cases:
- **Carry across a split boundary**, such as 0x0000FFFF + 1 or carry chains through all ones. A wrong mux select would leave the upper half one too small, or drop the carry-out while the sum bits looked correct.
- **Exhaustive 8-bit and 1-bit operands.** These catch a mis-sliced half or a leaf with swapped outputs that random 32-bit vectors might miss.
- **Paired cin=0 and cin=1 runs on the same operands.** These expose an upper-half copy tied to the wrong forced carry.
- **Mid-cycle sampling.** This catches any accidental register or latch on the outputs.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
  // R6: width legality test used at elaboration time
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/csa_full_adder.sv
`timescale 1ns/1ps
module csa_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));

  always_comb begin
    // R5: leaf result must match the arithmetic count of ones
    a_r5_leaf_exact: assert ({co, s} == (2'(x) + 2'(y) + 2'(ci)))
      else $error("leaf adder mismatch");
  end
endmodule

// File: rtl/csa_select_mux.sv
`timescale 1ns/1ps
module csa_select_mux #(
  parameter int unsigned W = 2
) (
  input  logic         pick_one,
  input  logic [W-1:0] when_zero,
  input  logic [W-1:0] when_one,
  output logic [W-1:0] chosen
);
  assign chosen = pick_one ? when_one : when_zero;
endmodule

// File: rtl/csa_node.sv
`timescale 1ns/1ps
module csa_node #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  generate
    if (W == 1) begin : g_leaf
      csa_full_adder u_fa (
        .x(x[0]), .y(y[0]), .ci(ci), .s(s[0]), .co(co)
      );
    end else begin : g_split
      localparam int unsigned H = W / 2;

      logic [H-1:0] lo_s;
      logic         lo_c;
      logic [H-1:0] hz_s, ho_s;
      logic         hz_c, ho_c;
      logic [H:0]   hi_pick;

      csa_node #(.W(H)) u_lo (
        .x(x[H-1:0]), .y(y[H-1:0]), .ci(ci), .s(lo_s), .co(lo_c)
      );
      csa_node #(.W(H)) u_hi_zero (
        .x(x[W-1:H]), .y(y[W-1:H]), .ci(1'b0), .s(hz_s), .co(hz_c)
      );
      csa_node #(.W(H)) u_hi_one (
        .x(x[W-1:H]), .y(y[W-1:H]), .ci(1'b1), .s(ho_s), .co(ho_c)
      );
      csa_select_mux #(.W(H + 1)) u_pick (
        .pick_one (lo_c),
        .when_zero({hz_c, hz_s}),
        .when_one ({ho_c, ho_s}),
        .chosen   (hi_pick)
      );

      assign s  = {hi_pick[H-1:0], lo_s};
      assign co = hi_pick[H];

      logic [H:0] lo_ref;
      logic [W:0] all_ref;
      always_comb begin
        lo_ref  = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, ci};
        all_ref = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        // R2: low half driven by real carry-in only
        a_r2_low_half: assert ({lo_c, lo_s} == lo_ref)
          else $error("low half mismatch");
        // R3: carry-one copy is exactly one above carry-zero copy
        a_r3_pair_step: assert ({ho_c, ho_s} == ({hz_c, hz_s} + (H+1)'(1)))
          else $error("upper pair inconsistent");
        // R4: selected upper result joined to low half gives full sum
        a_r4_join: assert ({co, s} == all_ref)
          else $error("joined result mismatch");
      end
    end
  endgenerate
endmodule

// File: rtl/cond_sum_adder.sv
`timescale 1ns/1ps
module cond_sum_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  // R6: refuse widths that cannot be halved down to one bit
  generate
    if (!csa_pkg::is_pow2(WIDTH)) begin : g_bad_width
      $error("cond_sum_adder: WIDTH must be a power of two");
    end
  endgenerate

  csa_node #(.W(WIDTH)) u_root (
    .x(a), .y(b), .ci(cin), .s(sum), .co(cout)
  );

  always_comb begin
    // R8: all-ones operands plus carry give all-ones with carry-out
    if ((&a) && (&b) && cin) begin
      a_r8_all_ones: assert ((&sum) && cout)
        else $error("all-ones case wrong");
    end
    // R9: carry ripples across the whole width
    if ((&a) && (b == '0) && cin) begin
      a_r9_full_ripple: assert ((sum == '0) && cout)
        else $error("full ripple case wrong");
    end
  end
endmodule

// File: tb/cond_sum_adder_tb_top.sv
`timescale 1ns/1ps
module cond_sum_adder_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  logic        a1, b1, c1, s1, co1;

  cond_sum_adder #(.WIDTH(32)) dut_i (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  cond_sum_adder #(.WIDTH(8))  dut8_i (.a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
  cond_sum_adder #(.WIDTH(1))  dut1_i (.a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] ref32(input logic [31:0] x, input logic [31:0] y, input logic c);
    longint unsigned t;
    t = longint'(x) + longint'(y) + longint'(c);
    return t[32:0];
  endfunction

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input logic c);
    @(negedge clk);
    a32 = x; b32 = y; c32 = c;
    #2;
  endtask

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a1 = 0; b1 = 0; c1 = 0;
    #3;
    // R1: quiet inputs give zero
    chk("R1 zero inputs", {31'b0, co32, s32}, 64'd0);

    // R6: legality rule for widths
    chk("R6 pow2 32", 64'(csa_pkg::is_pow2(32)), 64'd1);
    chk("R6 non-pow2 12", 64'(csa_pkg::is_pow2(12)), 64'd0);

    // R5: one-bit instance is a full adder
    for (int v = 0; v < 8; v++) begin
      {a1, b1, c1} = 3'(v);
      #1;
      chk("R5 leaf", 64'({co1, s1}), 64'(2'(a1) + 2'(b1) + 2'(c1)));
    end

    // R1: exhaustive 8-bit instance
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        for (int k = 0; k < 2; k++) begin
          a8 = 8'(i); b8 = 8'(j); c8 = 1'(k);
          #1;
          chk("R1 exhaustive8", 64'({co8, s8}), 64'(i + j + k));
        end
      end
    end

    // R4: carry crossing the top split boundary
    drive32(32'h0000_FFFF, 32'h0000_0001, 1'b0);
    chk("R4 boundary carry", {31'b0, co32, s32}, 64'h0_0001_0000);
    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R4 carry-out only", {31'b0, co32, s32}, 64'h1_0000_0000);

    // R8: all ones with carry-in
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk("R8 all ones", {31'b0, co32, s32}, 64'h1_FFFF_FFFF);

    // R9: full-width ripple
    drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R9 full ripple", {31'b0, co32, s32}, 64'h1_0000_0000);

    // R2: low half unaffected by high operand bits
    drive32(32'hABCD_8001, 32'h1234_7FFF, 1'b1);
    chk("R2 low half", 64'(s32[15:0]), 64'((32'h8001 + 32'h7FFF + 1) & 32'hFFFF));

    // R7: output follows input mid-cycle, no clock edge
    @(posedge clk);
    #1;
    a32 = 32'd100; b32 = 32'd23; c32 = 1'b0;
    #1;
    chk("R7 combinational", {31'b0, co32, s32}, 64'd123);

    // R3 and R1: random vectors, paired carry-in values
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x, y;
      logic [32:0] r0;
      x = $urandom(); y = $urandom();
      if (n % 7 == 0) x = 32'hFFFF_FFFF;
      drive32(x, y, 1'b0);
      r0 = {co32, s32};
      chk("R1 random cin0", 64'(r0), 64'(ref32(x, y, 1'b0)));
      drive32(x, y, 1'b1);
      chk("R1 random cin1", 64'({co32, s32}), 64'(ref32(x, y, 1'b1)));
      chk("R3 carry pair", 64'({co32, s32}), 64'(r0 + 33'd1));
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule